// File: doc/BRIEF.md
# Grouped Interrupt Control Register Bank

This block holds the per-group state of an interrupt controller with 31 groups of four interrupt inputs each. Every group keeps a 4-bit request vector, a 4-bit enable vector and a 3-bit priority level. All three are driven out in flat vectors so that a separate priority resolver can pick a winner. Groups 0 and 1 are non-maskable: their enable is fixed at all ones and their level at zero. Groups 2 to 30 are maskable groups whose level and enable software can program.

Software reaches the bank through a single-cycle byte bus with an address, write data, a write strobe and a read strobe. Each group owns four consecutive byte addresses. The trigger logic raises one set pulse per interrupt input. A set pulse lands in the request register on the next clock edge and wins over a clear that a bus write makes to the same bit in the same cycle, so no event is lost. Any write into a maskable group raises a one-cycle update strobe that tells the resolver to re-evaluate.

There is no state machine. Each group is a small register slice. A read path registers the selected byte, and a strobe flop flags writes to maskable groups.

Top module: `icr_bank`

## Requirements
- R1: After reset, every group's request is 0, its level is 0 and its enable is 4'hF. `bus_rdata` and `upd_strobe` are 0.
- R2: A byte address selects group = address / 4 and byte = address mod 4. For addresses 124 to 127 the group would be 31 or above; those addresses read 0 and writes to them change nothing.
- R3: For a maskable group, byte 0 reads the request in bits 7:4 and request AND enable in bits 3:0.
- R4: A write to byte 0 of a maskable group treats bits 7:4 as a select nibble S and bits 3:0 as a data nibble D. Per bit, the request is set when S=1 and D=1, cleared when S=0 and D=1, and kept when D=0.
- R5: Byte 1 of a maskable group reads and writes the level in bits 6:4 and the enable in bits 3:0. Bit 7 reads 0. Level and enable change only through this byte.
- R6: For a non-maskable group, byte 0 reads the request in bits 3:0 with bits 7:4 zero. Writing a 1 to any of bits 3:0 clears that request bit.
- R7: A non-maskable group keeps enable 4'hF and level 0 for good. Its byte 1 reads 0, and writes to that byte are ignored.
- R8: In every group, bytes 2 and 3 read 0 and writes to them change nothing.
- R9: `set_pulse[4*g+i]` sets bit i of group g's request at the next clock edge. This holds even when a bus write in the same cycle clears that bit.
- R10: `upd_strobe` is high for exactly the one cycle after a write to any byte of a maskable group. It stays low after writes to non-maskable groups or to out-of-range addresses.
- R11: `bus_rdata` is registered. It is valid in the cycle after `bus_re` and reflects the state from before a write in the same cycle. It holds its value while `bus_re` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per access |
| bus_re | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| set_pulse | input | 124 | Per-input request set pulses, bit 4*g+i for group g input i |
| grp_req | output | 124 | Request vectors, group g at bits 4g+3:4g |
| grp_en | output | 124 | Enable vectors, group g at bits 4g+3:4g |
| grp_lvl | output | 93 | Levels, group g at bits 3g+2:3g |
| upd_strobe | output | 1 | One-cycle pulse after a write to a maskable group |

## Verification
Every result of this block is due exactly one clock edge after its stimulus. Request, enable and level change on the edge that samples a write or set pulse, read data appears on the edge that samples `bus_re`, and `upd_strobe` rises on the edge that samples the write. The bench drives each access on a falling edge and lets one rising edge pass. It compares all outputs at the next falling edge against a model that it updated at that rising edge, using the pre-edge model for read data. Directed cases cover each encoding and the set-against-clear collision, and seeded random accesses over the full address range follow.

// File: rtl/icr_pkg.sv
package icr_pkg;

    localparam int REQ_W  = 4;
    localparam int LVL_W  = 3;
    localparam int BYTE_W = 8;

    // Byte slot inside one group's four-byte window.
    typedef enum logic [1:0] {
        SLOT_REQ  = 2'd0,
        SLOT_CTL  = 2'd1,
        SLOT_RSV2 = 2'd2,
        SLOT_RSV3 = 2'd3
    } slot_byte_e;

    // Per-bit request update for a maskable group: data bit picks whether
    // the bit is touched, select bit picks set (1) or clear (0).
    function automatic logic [REQ_W-1:0] req_upd_maskable(
        input logic [REQ_W-1:0]  cur,
        input logic [BYTE_W-1:0] wd
    );
        logic [REQ_W-1:0] res;
        for (int b = 0; b < REQ_W; b++) begin
            if (wd[b]) res[b] = wd[REQ_W + b];
            else       res[b] = cur[b];
        end
        return res;
    endfunction

endpackage

// File: rtl/icr_group.sv
module icr_group
    import icr_pkg::*;
#(
    parameter bit IS_NMI = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  slot_byte_e        byte_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [REQ_W-1:0]  set_in,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [REQ_W-1:0]  req_o,
    output logic [REQ_W-1:0]  en_o,
    output logic [LVL_W-1:0]  lvl_o
);

    logic [REQ_W-1:0] req_q;
    logic [REQ_W-1:0] en_q;
    logic [LVL_W-1:0] lvl_q;
    logic [REQ_W-1:0] req_bus;

    always_comb begin
        req_bus = req_q;
        if (wr_hit && byte_sel == SLOT_REQ) begin
            if (IS_NMI) req_bus = req_q & ~wdata[REQ_W-1:0];
            else        req_bus = req_upd_maskable(req_q, wdata);
        end
    end

    // Hardware set pulses are ORed in last so they override a bus clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_bus | set_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '1;
            lvl_q <= '0;
        end else if (!IS_NMI && wr_hit && byte_sel == SLOT_CTL) begin
            en_q  <= wdata[REQ_W-1:0];
            lvl_q <= wdata[REQ_W +: LVL_W];
        end
    end

    always_comb begin
        rd_byte = '0;
        unique case (byte_sel)
            SLOT_REQ: begin
                if (IS_NMI) rd_byte = {{(BYTE_W-REQ_W){1'b0}}, req_q};
                else        rd_byte = {req_q, req_q & en_q};
            end
            SLOT_CTL: begin
                if (!IS_NMI) rd_byte = {1'b0, lvl_q, en_q};
            end
            SLOT_RSV2,
            SLOT_RSV3: rd_byte = '0;
        endcase
    end

    assign req_o = req_q;
    assign en_o  = en_q;
    assign lvl_o = lvl_q;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_in != '0) |=> ((req_q & $past(set_in)) == $past(set_in)));

    assert_req_no_spurious_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> ((req_q & $past(req_q)) == $past(req_q)));

    assert_ctl_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && byte_sel == SLOT_CTL) |=> ($stable(en_q) && $stable(lvl_q)));

endmodule

// File: rtl/icr_readout.sv
module icr_readout
    import icr_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int GRP_IDX_W  = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic                         rd_valid,
    input  logic [GRP_IDX_W-1:0]         rd_grp,
    input  logic [NUM_GROUPS*BYTE_W-1:0] rd_bytes,
    output logic [BYTE_W-1:0]            rdata
);

    logic [BYTE_W-1:0] sel_byte;

    always_comb begin
        sel_byte = '0;
        if (rd_valid) sel_byte = rd_bytes[int'(rd_grp)*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= sel_byte;
    end

    assert_oob_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_valid) |=> (rdata == '0));

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/icr_bank.sv
module icr_bank
    import icr_pkg::*;
#(
    parameter int NUM_GROUPS = 31,
    parameter int NUM_NMI    = 2,
    parameter int ADDR_W     = 7,
    localparam int GRP_IDX_W = ADDR_W - 2,
    localparam int NIN       = NUM_GROUPS * REQ_W,
    localparam int NLV       = NUM_GROUPS * LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    input  logic [NIN-1:0]    set_pulse,
    output logic [NIN-1:0]    grp_req,
    output logic [NIN-1:0]    grp_en,
    output logic [NLV-1:0]    grp_lvl,
    output logic              upd_strobe
);

    logic [GRP_IDX_W-1:0]         grp_idx;
    slot_byte_e                   byte_sel;
    logic                         in_range;
    logic                         maskable_hit;
    logic [NUM_GROUPS*BYTE_W-1:0] rd_bytes;
    logic                         upd_q;

    assign grp_idx      = bus_addr[ADDR_W-1:2];
    assign byte_sel     = slot_byte_e'(bus_addr[1:0]);
    assign in_range     = int'(grp_idx) < NUM_GROUPS;
    assign maskable_hit = in_range && (int'(grp_idx) >= NUM_NMI);

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        logic wr_hit;
        assign wr_hit = bus_we && in_range && (grp_idx == GRP_IDX_W'(g));

        icr_group #(.IS_NMI(g < NUM_NMI)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (wr_hit),
            .byte_sel (byte_sel),
            .wdata    (bus_wdata),
            .set_in   (set_pulse[g*REQ_W +: REQ_W]),
            .rd_byte  (rd_bytes[g*BYTE_W +: BYTE_W]),
            .req_o    (grp_req[g*REQ_W +: REQ_W]),
            .en_o     (grp_en[g*REQ_W +: REQ_W]),
            .lvl_o    (grp_lvl[g*LVL_W +: LVL_W])
        );
    end

    icr_readout #(.NUM_GROUPS(NUM_GROUPS), .GRP_IDX_W(GRP_IDX_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (bus_re),
        .rd_valid (in_range),
        .rd_grp   (grp_idx),
        .rd_bytes (rd_bytes),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= bus_we && maskable_hit;
    end

    assign upd_strobe = upd_q;

    assert_strobe_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_strobe |-> $past(bus_we));

    assert_strobe_follows_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && maskable_hit) |=> upd_strobe);

    assert_oob_write_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !in_range && set_pulse == '0) |=>
            ($stable(grp_req) && $stable(grp_en) && $stable(grp_lvl) && !upd_strobe));

endmodule

// File: tb/icr_bank_tb.sv
`timescale 1ns/1ps
module icr_bank_tb;

    localparam int NG  = 31;
    localparam int NIN = NG * 4;
    localparam int NLV = NG * 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [6:0]     bus_addr = '0;
    logic [7:0]     bus_wdata = '0;
    logic           bus_we = 1'b0;
    logic           bus_re = 1'b0;
    logic [7:0]     bus_rdata;
    logic [NIN-1:0] set_pulse = '0;
    logic [NIN-1:0] grp_req;
    logic [NIN-1:0] grp_en;
    logic [NLV-1:0] grp_lvl;
    logic           upd_strobe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [3:0] m_req [NG];
    logic [3:0] m_en  [NG];
    logic [2:0] m_lvl [NG];
    logic [7:0] m_rdata;

    always #10 clk = ~clk;

    icr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .set_pulse(set_pulse), .grp_req(grp_req), .grp_en(grp_en),
        .grp_lvl(grp_lvl), .upd_strobe(upd_strobe)
    );

    function automatic logic [7:0] exp_rd(input logic [6:0] a);
        int g = int'(a >> 2);
        int b = int'(a & 7'd3);
        if (g >= NG) return 8'h00;
        if (g < 2) return (b == 0) ? {4'h0, m_req[g]} : 8'h00;
        case (b)
            0:       return {m_req[g], m_req[g] & m_en[g]};
            1:       return {1'b0, m_lvl[g], m_en[g]};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_wr(input logic [6:0] a, input logic [7:0] d);
        int g = int'(a >> 2);
        int b = int'(a & 7'd3);
        logic [3:0] s = d[7:4];
        logic [3:0] v = d[3:0];
        if (g >= NG) return;
        if (g < 2) begin
            if (b == 0) m_req[g] = m_req[g] & ~v;
        end else if (b == 0) begin
            m_req[g] = (s & v) | (s & m_req[g]) | (~s & ~v & m_req[g]);
        end else if (b == 1) begin
            m_lvl[g] = d[6:4];
            m_en[g]  = v;
        end
    endtask

    task automatic chk(input string req, input string what, input logic [255:0] act,
                       input logic [255:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_state(input string req);
        logic [NIN-1:0] er, ee;
        logic [NLV-1:0] el;
        for (int g = 0; g < NG; g++) begin
            er[g*4 +: 4] = m_req[g];
            ee[g*4 +: 4] = m_en[g];
            el[g*3 +: 3] = m_lvl[g];
        end
        chk(req, "grp_req", 256'(grp_req), 256'(er));
        chk(req, "grp_en",  256'(grp_en),  256'(ee));
        chk(req, "grp_lvl", 256'(grp_lvl), 256'(el));
    endtask

    // One access: driven on a falling edge, sampled at the next falling edge.
    task automatic op(input string req, input logic we, input logic re,
                      input logic [6:0] a, input logic [7:0] d, input logic [NIN-1:0] sp);
        logic exp_strobe;
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d; set_pulse = sp;
        if (re) m_rdata = exp_rd(a);
        exp_strobe = we && (int'(a >> 2) >= 2) && (int'(a >> 2) < NG);
        if (we) model_wr(a, d);
        for (int i = 0; i < NIN; i++) if (sp[i]) m_req[i/4][i%4] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b0; set_pulse = '0;
        chk_state(req);
        chk(req, "bus_rdata R11", 256'(bus_rdata), 256'(m_rdata));
        chk("R10", "upd_strobe", 256'(upd_strobe), 256'(exp_strobe));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [NIN-1:0] sp;
        void'($urandom(32'h5EED_1C4B));
        for (int g = 0; g < NG; g++) begin
            m_req[g] = 4'h0; m_en[g] = 4'hF; m_lvl[g] = 3'h0;
        end
        m_rdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk_state("R1");
        chk("R1", "bus_rdata", 256'(bus_rdata), 256'(0));
        chk("R1", "upd_strobe", 256'(upd_strobe), 256'(0));

        // R5 level/enable program and readback (group 5, addresses 20..23)
        op("R5", 1, 0, 7'd21, 8'hB5, '0);
        op("R5", 0, 1, 7'd21, 8'h00, '0);
        // R4 set all requests, R3 readback with enable 0101
        op("R4", 1, 0, 7'd20, 8'hFF, '0);
        op("R3", 0, 1, 7'd20, 8'h00, '0);
        // R4 clear bits 1 and 3, then keep cases S=1/D=0 and S=0/D=0
        op("R4", 1, 0, 7'd20, 8'h0A, '0);
        op("R4", 1, 0, 7'd20, 8'hA0, '0);
        op("R4", 1, 0, 7'd20, 8'h00, '0);
        op("R3", 0, 1, 7'd20, 8'h00, '0);
        // R8 reserved bytes
        op("R8", 1, 0, 7'd22, 8'hFF, '0);
        op("R8", 0, 1, 7'd23, 8'h00, '0);
        // R6 non-maskable group 1: set pulses, readback, write-one-to-clear
        sp = '0; sp[4 +: 4] = 4'hF;
        op("R6", 0, 0, 7'd4, 8'h00, sp);
        op("R6", 0, 1, 7'd4, 8'h00, '0);
        op("R6", 1, 0, 7'd4, 8'hF5, '0);
        op("R6", 0, 1, 7'd4, 8'h00, '0);
        // R7 non-maskable byte 1 ignored
        op("R7", 1, 0, 7'd1, 8'h7A, '0);
        op("R7", 0, 1, 7'd1, 8'h00, '0);
        // R2 out-of-range addresses
        op("R2", 1, 0, 7'd124, 8'hFF, '0);
        op("R2", 1, 0, 7'd125, 8'h7F, '0);
        op("R2", 0, 1, 7'd127, 8'h00, '0);
        // R9 set pulse wins over same-cycle clear, maskable and non-maskable
        sp = '0; sp[5*4 + 2] = 1'b1;
        op("R9", 1, 0, 7'd20, 8'h04, sp);
        sp = '0; sp[0] = 1'b1;
        op("R9", 1, 0, 7'd0, 8'h01, sp);
        // R11 read sees pre-write state, then holds
        op("R11", 1, 1, 7'd20, 8'h0F, '0);
        op("R11", 0, 0, 7'd20, 8'h00, '0);
        // R10 last group boundary
        op("R10", 1, 0, 7'd123, 8'h00, '0);

        for (int n = 0; n < 4000; n++) begin
            logic       we = 1'($urandom % 2);
            logic       re = 1'($urandom % 2);
            logic [6:0] a  = 7'($urandom);
            logic [7:0] d  = 8'($urandom);
            sp = '0;
            if ($urandom % 3 == 0) sp[$urandom % NIN] = 1'b1;
            if (we && ($urandom % 4 == 0)) sp[int'(a >> 2) * 4 + ($urandom % 4)] = 1'b1 & (int'(a >> 2) < NG);
            op("R4", we, re, a, d, sp);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule